// File: doc/BRIEF.md
# Time-Multiplexed Max-Star Add-Compare-Select Unit

This block evaluates the Jacobian logarithm, max*(a,b) = max(a,b) + ln(1 + e^-|a-b|). It is the core kernel of log-domain soft-decision decoders. The block does not use a wide combinational comparator and lookup table. It reuses one narrow add-compare-select (ACS) datapath over four consecutive clock cycles, and that datapath performs exactly one ACS operation per cycle. Inputs and outputs are two's-complement fixed-point log-likelihood values with two fraction bits, so one LSB is worth 0.25.

A one-cycle start strobe does two things:
- It captures the two operands into working registers R1 and R2.
- It picks a mode.

In max* mode a small sequencer steers the datapath through four steps:
1. An inexact absolute difference goes into R3, and flag C0 records which operand is larger.
2. The difference is tested against 0.75 and the outcome is latched into C1.
3. The difference is tested against 0 or 2, depending on C1, and the outcome is latched into C2.
4. The larger operand is added to a quantised correction term and the sum is saturated.

The add, subtract and max modes use the same datapath for a single operation. A done strobe marks the cycle in which the result register holds the new value.

Top module: `maxstar_acs`

## Requirements
- R1: While reset is asserted, and after it is released with no accepted start, `done` is 0 and `result` is 0.
- R2: A start accepted in mode 2'b00 (max*) on clock edge k leaves `result` updated and `done` high after edge k+4, for exactly that one cycle.
- R3: The max* difference term d is a-b when a >= b, and b-a minus one LSB when a < b. For example, a=0 and b=0.25 give d=0.
- R4: The max* result is max(a,b) plus a correction. The correction is 0.75 for d <= 0, 0.5 for 0 < d <= 0.75, 0.25 for 0.75 < d <= 2, and 0 for d > 2.
- R5: When max(a,b) plus the correction exceeds the most positive code, the max* result is clamped to the most positive code.
- R6: Mode 2'b01 (add) returns a+b, saturated at both ends of the range, with `done` high after edge k+1.
- R7: Mode 2'b10 (subtract) returns a-b, saturated at both ends of the range, with `done` high after edge k+1.
- R8: Mode 2'b11 (max) returns the larger of a and b, with `done` high after edge k+1.
- R9: A start that arrives while a sequence is in progress is ignored. It does not alter that sequence's result and it does not produce a second `done` pulse. `done` never stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, sampled only while idle |
| mode | input | 2 | 00 max*, 01 add, 10 subtract, 11 max |
| opA | input | DATA_W | Operand a, two's complement, FRAC_W fraction bits |
| opB | input | DATA_W | Operand b, same format |
| result | output | DATA_W | Last completed result, held until the next completion |
| done | output | 1 | One-cycle strobe marking a new result |

## Verification
Every pair of 6-bit operands passes through max* mode, so each threshold boundary of the correction is covered from both sides.

One directed pair hits the one-LSB inexactness when a < b. If the difference were computed exactly there, the result would come out 0.25 low.

Large equal operands push the sum past the top code. A design that wrapped there would return a large negative value instead of the clamped maximum.

A start held high during a busy sequence, carrying different operands and a different mode, would show up as an early `done` or a corrupted result if the sequencer let it through.

// File: rtl/maxstar_pkg.sv
package maxstar_pkg;

  // Mode selector at the block edge
  typedef enum logic [1:0] {
    MODE_MAXSTAR = 2'b00,
    MODE_ADD     = 2'b01,
    MODE_SUB     = 2'b10,
    MODE_MAX     = 2'b11
  } mode_e;

  // ACS operation codes. Bit 5 = subtract q from p, bit 4 = flag test only,
  // bit 3 = absolute value into R3, bit 2 = select, bits 1:0 = flag to write.
  localparam logic [5:0] OPC_SUM   = 6'b000000;
  localparam logic [5:0] OPC_DIFF  = 6'b100000;
  localparam logic [5:0] OPC_PICK  = 6'b100100;
  localparam logic [5:0] OPC_ABSD  = 6'b101100;
  localparam logic [5:0] OPC_TEST1 = 6'b110010;
  localparam logic [5:0] OPC_TEST2 = 6'b110001;

  typedef enum logic [1:0] {
    PSRC_R1     = 2'd0,
    PSRC_LARGER = 2'd1,
    PSRC_K075   = 2'd2,
    PSRC_KSTEP  = 2'd3
  } psrc_e;

  typedef enum logic [1:0] {
    QSRC_R2   = 2'd0,
    QSRC_R3   = 2'd1,
    QSRC_CORR = 2'd2
  } qsrc_e;

  typedef struct packed {
    logic       load;
    logic       exec;
    logic [5:0] opcode;
    psrc_e      pSrc;
    qsrc_e      qSrc;
  } ctrl_t;

endpackage

// File: rtl/maxstar_ctrl.sv
module maxstar_ctrl
  import maxstar_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  start,
  input  mode_e mode,
  output ctrl_t ctrl
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ABS, ST_TEST1, ST_TEST2, ST_FINAL, ST_SINGLE
  } state_e;

  state_e state;
  mode_e  heldMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      heldMode <= MODE_MAXSTAR;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          heldMode <= mode;
          state    <= (mode == MODE_MAXSTAR) ? ST_ABS : ST_SINGLE;
        end
        ST_ABS:   state <= ST_TEST1;
        ST_TEST1: state <= ST_TEST2;
        ST_TEST2: state <= ST_FINAL;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrl        = '0;
    ctrl.pSrc   = PSRC_R1;
    ctrl.qSrc   = QSRC_R2;
    ctrl.opcode = OPC_SUM;
    ctrl.load   = (state == ST_IDLE) && start;
    case (state)
      ST_ABS: begin
        ctrl.exec = 1'b1; ctrl.opcode = OPC_ABSD;
      end
      ST_TEST1: begin
        ctrl.exec = 1'b1; ctrl.opcode = OPC_TEST1;
        ctrl.pSrc = PSRC_K075; ctrl.qSrc = QSRC_R3;
      end
      ST_TEST2: begin
        ctrl.exec = 1'b1; ctrl.opcode = OPC_TEST2;
        ctrl.pSrc = PSRC_KSTEP; ctrl.qSrc = QSRC_R3;
      end
      ST_FINAL: begin
        ctrl.exec = 1'b1; ctrl.opcode = OPC_SUM;
        ctrl.pSrc = PSRC_LARGER; ctrl.qSrc = QSRC_CORR;
      end
      ST_SINGLE: begin
        ctrl.exec = 1'b1;
        case (heldMode)
          MODE_SUB: ctrl.opcode = OPC_DIFF;
          MODE_MAX: ctrl.opcode = OPC_PICK;
          default:  ctrl.opcode = OPC_SUM;
        endcase
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/maxstar_dp.sv
module maxstar_dp
  import maxstar_pkg::*;
#(
  parameter int DATA_W = 6,
  parameter int FRAC_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctrl,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic              done
);

  localparam int EW = DATA_W + 2;
  localparam logic [EW-1:0] K075  = EW'(3 << (FRAC_W - 2));
  localparam logic [EW-1:0] K050  = EW'(2 << (FRAC_W - 2));
  localparam logic [EW-1:0] K025  = EW'(1 << (FRAC_W - 2));
  localparam logic [EW-1:0] KTWO  = EW'(2 << FRAC_W);
  localparam logic [DATA_W-1:0] MAXPOS = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] MINNEG = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] r1, r2;
  logic [DATA_W:0]   r3;
  logic              c0, c1, c2;

  logic [EW-1:0]     pOp, qOp, qEff, sum, corr;
  logic [DATA_W:0]   absVal;
  logic [DATA_W-1:0] satVal, pickVal;
  logic [2:0]        hiBits;
  logic              subtract, neg, inRange;

  always_comb begin
    case ({c1, c2})
      2'b00:   corr = K075;
      2'b01:   corr = K050;
      2'b10:   corr = K025;
      default: corr = '0;
    endcase

    case (ctrl.pSrc)
      PSRC_R1:     pOp = {{2{r1[DATA_W-1]}}, r1};
      PSRC_LARGER: pOp = c0 ? {{2{r1[DATA_W-1]}}, r1} : {{2{r2[DATA_W-1]}}, r2};
      PSRC_K075:   pOp = K075;
      default:     pOp = c1 ? KTWO : '0;
    endcase

    case (ctrl.qSrc)
      QSRC_R2:   qOp = {{2{r2[DATA_W-1]}}, r2};
      QSRC_R3:   qOp = {1'b0, r3};
      default:   qOp = corr;
    endcase

    subtract = ctrl.opcode[5];
    qEff     = subtract ? ~qOp : qOp;
    sum      = pOp + qEff + EW'(subtract);
    neg      = sum[EW-1];
    // ones' complement of a negative difference: no increment stage
    absVal   = neg ? ~sum[DATA_W:0] : sum[DATA_W:0];
    hiBits   = sum[EW-1:DATA_W-1];
    inRange  = (hiBits == 3'b000) || (hiBits == 3'b111);
    satVal   = inRange ? sum[DATA_W-1:0] : (neg ? MINNEG : MAXPOS);
    pickVal  = neg ? qOp[DATA_W-1:0] : pOp[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      r1 <= '0; r2 <= '0; r3 <= '0;
      c0 <= 1'b0; c1 <= 1'b0; c2 <= 1'b0;
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (ctrl.load) begin
        r1 <= opA;
        r2 <= opB;
      end
      if (ctrl.exec) begin
        case (ctrl.opcode)
          OPC_ABSD: begin
            r3 <= absVal;
            c0 <= ~neg;
          end
          OPC_TEST1: c1 <= neg;
          OPC_TEST2: c2 <= neg;
          OPC_PICK: begin
            result <= pickVal;
            done   <= 1'b1;
          end
          OPC_SUM, OPC_DIFF: begin
            result <= satVal;
            done   <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/maxstar_acs.sv
module maxstar_acs
  import maxstar_pkg::*;
#(
  parameter int DATA_W = 6,
  parameter int FRAC_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic              done
);

  ctrl_t ctrl;

  maxstar_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .mode  (mode_e'(mode)),
    .ctrl  (ctrl)
  );

  maxstar_dp #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctrl   (ctrl),
    .opA    (opA),
    .opB    (opB),
    .result (result),
    .done   (done)
  );

endmodule

// File: rtl/maxstar_acs_chk.sv
module maxstar_acs_chk #(
  parameter int DATA_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [1:0]        mode,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic [DATA_W-1:0] result,
  input logic              done
);

  localparam logic signed [DATA_W-1:0] TOPCODE = {1'b0, {(DATA_W-1){1'b1}}};

  logic [2:0]               pend;
  logic [1:0]               latMode;
  logic signed [DATA_W-1:0] latA, latB, larger;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend <= '0; latMode <= '0; latA <= '0; latB <= '0;
    end else if (pend == 3'd0) begin
      if (start) begin
        pend    <= (mode == 2'b00) ? 3'd4 : 3'd1;
        latMode <= mode;
        latA    <= opA;
        latB    <= opB;
      end
    end else begin
      pend <= pend - 3'd1;
    end
  end

  assign larger = (latA > latB) ? latA : latB;

  assert_done_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    (pend == 3'd1) |=> done);

  assert_no_extra_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    (pend != 3'd1) |=> !done);

  assert_result_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(result) |-> done);

  assert_floor_R4: assert property (@(posedge clk) disable iff (!rstN)
    (done && latMode == 2'b00) |-> ($signed(result) >= larger));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rstN)
    (done && latMode == 2'b00 && larger == TOPCODE) |-> ($signed(result) == TOPCODE));

  assert_pick_R8: assert property (@(posedge clk) disable iff (!rstN)
    (done && latMode == 2'b11) |-> ($signed(result) == larger));

endmodule

bind maxstar_acs maxstar_acs_chk #(.DATA_W(DATA_W)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .mode   (mode),
  .opA    (opA),
  .opB    (opB),
  .result (result),
  .done   (done)
);

// File: tb/maxstar_acs_tb.sv
module maxstar_acs_tb;

  localparam int W      = 6;
  localparam int MAXPOS = (1 << (W - 1)) - 1;
  localparam int MINNEG = -(1 << (W - 1));

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic [W-1:0] result;
  logic         done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  maxstar_acs #(.DATA_W(W), .FRAC_W(2)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode),
    .opA(opA), .opB(opB), .result(result), .done(done)
  );

  always #5 clk = ~clk;

  // Reference from the requirements: LSB = 0.25, 0.75 = 3 LSB, 2 = 8 LSB
  function automatic int refOp(int m, int a, int b);
    int d, mx, c, s;
    mx = (a > b) ? a : b;
    case (m)
      0: begin
        d = (a >= b) ? a - b : b - a - 1;
        c = (d <= 0) ? 3 : (d <= 3) ? 2 : (d <= 8) ? 1 : 0;
        s = mx + c;
      end
      1: s = a + b;
      2: s = a - b;
      default: s = mx;
    endcase
    if (s > MAXPOS) s = MAXPOS;
    if (s < MINNEG) s = MINNEG;
    return s;
  endfunction

  function automatic int sx(logic [W-1:0] v);
    return int'($signed(v));
  endfunction

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  // Called at a negedge; returns at the negedge where the result is due
  task automatic runOp(input int m, input int a, input int b, input string tag);
    int lat;
    int expv;
    lat  = (m == 0) ? 4 : 1;
    expv = refOp(m, a, b);
    start = 1'b1; mode = m[1:0]; opA = a[W-1:0]; opB = b[W-1:0];
    @(negedge clk);
    start = 1'b0;
    repeat (lat) @(negedge clk);
    check({tag, " done"}, int'(done), 1);
    check({tag, " result"}, sx(result), expv);
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog R2 actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int r;
    r = $urandom(32'h5eed_1234);
    repeat (3) @(negedge clk);
    check("R1 done in reset", int'(done), 0);
    check("R1 result in reset", sx(result), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 done after reset", int'(done), 0);
    check("R1 result after reset", sx(result), 0);

    // Directed max* corners
    runOp(0, 4, 4, "R4 d=0");
    runOp(0, 0, 1, "R3 a<b one-lsb");
    runOp(0, 2, 5, "R3 a<b d=2");
    runOp(0, 5, 2, "R4 d=3");
    runOp(0, 6, 2, "R4 d=4");
    runOp(0, 10, 2, "R4 d=8");
    runOp(0, 11, 2, "R4 d=9");
    runOp(0, 31, 31, "R5 clamp");
    runOp(0, 30, 29, "R5 clamp near top");
    runOp(0, -32, -32, "R4 bottom");

    // Exhaustive max*
    for (int a = MINNEG; a <= MAXPOS; a++)
      for (int b = MINNEG; b <= MAXPOS; b++)
        runOp(0, a, b, "R2 R4 sweep");

    // Single-cycle modes: corners then random
    runOp(1, 31, 31, "R6 add high");
    runOp(1, -32, -32, "R6 add low");
    runOp(2, -32, 31, "R7 sub low");
    runOp(2, 31, -32, "R7 sub high");
    runOp(3, -1, -32, "R8 max");
    runOp(3, -32, -32, "R8 max equal");
    for (int i = 0; i < 300; i++) begin
      runOp(1, sx(W'($urandom)), sx(W'($urandom)), "R6 add");
      runOp(2, sx(W'($urandom)), sx(W'($urandom)), "R7 sub");
      runOp(3, sx(W'($urandom)), sx(W'($urandom)), "R8 max");
    end

    // Start held high during a running max*
    start = 1'b1; mode = 2'b00; opA = W'(2); opB = W'(2);
    @(negedge clk);
    mode = 2'b01; opA = W'(10); opB = W'(10);
    @(negedge clk);
    check("R9 no early done", int'(done), 0);
    @(negedge clk);
    check("R9 no early done 2", int'(done), 0);
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check("R9 done", int'(done), 1);
    check("R9 result kept", sx(result), refOp(0, 2, 2));
    @(negedge clk);
    check("R9 single pulse", int'(done), 0);
    check("R9 result held", sx(result), refOp(0, 2, 2));
    repeat (3) @(negedge clk);
    check("R9 no late done", int'(done), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule